// File: doc/BRIEF.md
# Floppy Seek and Recalibrate Stepper

This block moves the heads of up to four floppy drives for the two positioning commands. A seek moves the head to a target cylinder. A recalibrate moves the head outward until the drive reports track zero. A one-cycle start strobe supplies the drive number, the head, the target cylinder, the command kind and a 4-bit step-rate code. The block then raises a direction level and emits step pulses. All step timing is counted in ticks of an external 1 ms strobe. The block keeps a present-cylinder register for each drive and flags the moving drive on a one-hot busy vector. When the command ends it latches the first status byte (ST0) and raises an interrupt.

Software answers the interrupt with a sense request. One cycle later the block presents ST0 and the present cylinder of the drive that finished, and it drops the interrupt.

A single state machine sequences each command. It has five states:
- IDLE accepts a start. It goes to SETTLE when the head has to move, or straight to DONE when there is nothing to move.
- SETTLE holds the new direction level. It leaves for PULSE on the second tick after the start.
- PULSE keeps the step output high until the next tick, then goes to GAP.
- GAP keeps the step output low for (16 − rate) ticks. It then goes back to PULSE, or to DONE when the seek count is used up, when track zero is seen, or when the recalibrate step limit is reached.
- DONE builds ST0, raises the interrupt and returns to IDLE.

Top module: `fdc_seek_stepper`

## Requirements
- R1: After reset, step_o, busy_o, irq_o and sense_valid_o are 0, and every present cylinder is 0.
- R2: A seek drives dir_o to 1 when the target is above the present cylinder and to 0 otherwise. A recalibrate drives dir_o to 0. dir_o is set in the cycle after the start is accepted and does not change while step_o is high.
- R3: A seek issues exactly |target − present| step pulses and leaves the present cylinder at the target. A seek whose target equals the present cylinder completes with no pulse.
- R4: Each step pulse is high from one tick to the next. The first pulse begins no earlier than the second tick after the start, so dir_o is steady for at least one full tick before it.
- R5: The step-rate code N (0..15) is latched at start. The low time between pulses is (16 − N) ticks, so code 0 gives 16 ticks and code 15 gives 1 tick.
- R6: While a command runs on drive d, busy_o has only bit d set and sel_drive_o equals d. When idle, busy_o is 0.
- R7: A start that arrives while a command is running is ignored. It changes neither the running command nor any present cylinder.
- R8: A recalibrate pulses outward and checks the track-zero input of its drive at the end of each gap. When track zero is already high at the start, it completes with no pulse. On success the present cylinder becomes 0 and ST0 bits 7..6 are 00.
- R9: When track zero has not been seen after 77 pulses, the recalibrate ends. ST0 then has bit 4 (equipment check) set and bits 7..6 = 01.
- R10: At completion irq_o rises. ST0 holds bits 7..6 = termination, bit 5 = 1 (seek end), bit 4 = equipment check, bit 3 = 0, bit 2 = head (0 for a recalibrate) and bits 1..0 = drive.
- R11: In the cycle after sense_req, sense_valid_o is high with the pending ST0 on sense_st0_o and that drive's present cylinder on sense_cyl_o. irq_o is then low.
- R12: A sense request with no interrupt pending returns ST0 = 80h and cylinder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| start | input | 1 | One-cycle command strobe |
| start_recal | input | 1 | 1 = recalibrate, 0 = seek |
| start_drive | input | 2 | Drive number |
| start_head | input | 1 | Head reported in ST0 for a seek |
| start_cyl | input | 8 | Seek target cylinder |
| step_rate | input | 4 | Step-rate code N; gap = 16 − N ticks |
| trk0 | input | 4 | Track-zero level, one bit per drive |
| sense_req | input | 1 | One-cycle sense-interrupt request |
| step_o | output | 1 | Step pulse to the selected drive |
| dir_o | output | 1 | 1 = toward higher cylinders |
| sel_drive_o | output | 2 | Drive being moved |
| busy_o | output | 4 | One-hot busy flag for each drive |
| irq_o | output | 1 | Interrupt pending |
| sense_valid_o | output | 1 | Sense answer valid |
| sense_st0_o | output | 8 | Sense answer: ST0 |
| sense_cyl_o | output | 8 | Sense answer: present cylinder |

## Verification
A behavioural reference model is compared with the design on every clock. It is exercised by:
- A seek to the present cylinder, which separates the no-pulse shortcut from a pulse sequence.
- An outward seek and an inward seek at the fastest and slowest rate codes. These separate direction errors, pulse-count errors and off-by-one errors in the gap length.
- Three recalibrates: one that finds track zero after two pulses, one that starts already on track zero, and one that never sees it. These tell the normal and equipment-check endings apart and expose a wrong step limit.
- A start strobe on another drive during a running seek, and sense requests with and without a pending interrupt. These check that a busy command cannot be disturbed and that the 80h answer is returned when nothing is pending.

// File: rtl/fstep_pkg.sv
package fstep_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_PULSE,
        PH_GAP,
        PH_DONE
    } phase_t;

    localparam logic [1:0] TERM_OK  = 2'b00;
    localparam logic [1:0] TERM_ABN = 2'b01;
    localparam logic [7:0] ST0_NONE = 8'h80;

    // Status byte: termination, seek end, equipment check, not-ready, head, drive
    function automatic logic [7:0] make_st0(input logic [1:0] term, input logic eq_chk,
                                            input logic head, input logic [1:0] drv);
        return {term, 1'b1, eq_chk, 1'b0, head, drv};
    endfunction

endpackage

// File: rtl/fstep_wait.sv
module fstep_wait #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = tick && (cnt_q == '0);
endmodule

// File: rtl/fstep_cyl_bank.sv
module fstep_cyl_bank #(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8,
    parameter int DRV_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             step_up,
    input  logic             clear,
    input  logic [DRV_W-1:0] wr_drv,
    input  logic [DRV_W-1:0] rd_a_drv,
    input  logic [DRV_W-1:0] rd_b_drv,
    output logic [CYL_W-1:0] rd_a,
    output logic [CYL_W-1:0] rd_b
);
    logic [CYL_W-1:0] cyl_w [NUM_DRIVES];

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        logic [CYL_W-1:0] val_q;
        logic             hit;
        assign hit = (wr_drv == DRV_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (hit && clear)
                val_q <= '0;
            else if (hit && step_en) begin
                if (step_up)
                    val_q <= val_q + 1'b1;
                else if (val_q != '0)
                    val_q <= val_q - 1'b1;
            end
        end

        assign cyl_w[g] = val_q;
    end

    assign rd_a = cyl_w[rd_a_drv];
    assign rd_b = cyl_w[rd_b_drv];
endmodule

// File: rtl/fstep_report.sv
module fstep_report
    import fstep_pkg::*;
#(
    parameter int CYL_W = 8,
    parameter int DRV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             fail,
    input  logic             head,
    input  logic [DRV_W-1:0] drv,
    input  logic             sense_req,
    input  logic [CYL_W-1:0] pend_cyl,
    output logic             irq_o,
    output logic [DRV_W-1:0] pend_drv,
    output logic             sense_valid_o,
    output logic [7:0]       sense_st0_o,
    output logic [CYL_W-1:0] sense_cyl_o
);
    logic [7:0] st0_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o         <= 1'b0;
            st0_q         <= '0;
            pend_drv      <= '0;
            sense_valid_o <= 1'b0;
            sense_st0_o   <= '0;
            sense_cyl_o   <= '0;
        end else begin
            sense_valid_o <= sense_req;
            if (sense_req) begin
                sense_st0_o <= irq_o ? st0_q : ST0_NONE;
                sense_cyl_o <= irq_o ? pend_cyl : '0;
            end
            if (done) begin
                irq_o    <= 1'b1;
                st0_q    <= make_st0(fail ? TERM_ABN : TERM_OK, fail, head, 2'(drv));
                pend_drv <= drv;
            end else if (sense_req) begin
                irq_o <= 1'b0;
            end
        end
    end

    // R11
    sense_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_valid_o |-> $past(sense_req));

    // R10
    irq_seek_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> st0_q[5]);
endmodule

// File: rtl/fdc_seek_stepper.sv
module fdc_seek_stepper
    import fstep_pkg::*;
#(
    parameter int  NUM_DRIVES  = 4,
    parameter int  CYL_W       = 8,
    parameter int  RATE_W      = 4,
    parameter int  RECAL_LIMIT = 77,
    localparam int DRV_W       = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_ms,
    input  logic                  start,
    input  logic                  start_recal,
    input  logic [DRV_W-1:0]      start_drive,
    input  logic                  start_head,
    input  logic [CYL_W-1:0]      start_cyl,
    input  logic [RATE_W-1:0]     step_rate,
    input  logic [NUM_DRIVES-1:0] trk0,
    input  logic                  sense_req,
    output logic                  step_o,
    output logic                  dir_o,
    output logic [DRV_W-1:0]      sel_drive_o,
    output logic [NUM_DRIVES-1:0] busy_o,
    output logic                  irq_o,
    output logic                  sense_valid_o,
    output logic [7:0]            sense_st0_o,
    output logic [CYL_W-1:0]      sense_cyl_o
);
    localparam int TRY_W = $clog2(RECAL_LIMIT + 1);

    phase_t             state_q, state_d;
    logic [DRV_W-1:0]   drv_q;
    logic               head_q, recal_q, dir_q, fail_q;
    logic [RATE_W-1:0]  rate_q;
    logic [CYL_W-1:0]   remain_q;
    logic [TRY_W-1:0]   tries_q;
    logic [CYL_W-1:0]   cyl_start, cyl_pend;
    logic [DRV_W-1:0]   pend_drv;
    logic               accept, pulse_tick, wait_exp, start_nothing, gap_finish, gap_end;
    logic [RATE_W-1:0]  wait_load_val;

    assign accept        = (state_q == PH_IDLE) && start;
    assign pulse_tick    = (state_q == PH_PULSE) && tick_ms;
    assign start_nothing = start_recal ? trk0[start_drive] : (start_cyl == cyl_start);
    assign gap_finish    = recal_q ? (trk0[drv_q] || tries_q == TRY_W'(RECAL_LIMIT))
                                   : (remain_q == '0);
    assign gap_end       = (state_q == PH_GAP) && wait_exp && gap_finish;
    assign wait_load_val = accept ? RATE_W'(1) : ~rate_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (start)    state_d = start_nothing ? PH_DONE : PH_SETTLE;
            PH_SETTLE: if (wait_exp) state_d = PH_PULSE;
            PH_PULSE:  if (tick_ms)  state_d = PH_GAP;
            PH_GAP:    if (wait_exp) state_d = gap_finish ? PH_DONE : PH_PULSE;
            PH_DONE:                 state_d = PH_IDLE;
            default:                 state_d = PH_IDLE;
        endcase
    end

    // Command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q    <= '0;
            head_q   <= 1'b0;
            recal_q  <= 1'b0;
            dir_q    <= 1'b0;
            fail_q   <= 1'b0;
            rate_q   <= '0;
            remain_q <= '0;
            tries_q  <= '0;
        end else if (accept) begin
            drv_q    <= start_drive;
            head_q   <= start_recal ? 1'b0 : start_head;
            recal_q  <= start_recal;
            dir_q    <= !start_recal && (start_cyl > cyl_start);
            fail_q   <= 1'b0;
            rate_q   <= step_rate;
            remain_q <= (start_cyl > cyl_start) ? start_cyl - cyl_start : cyl_start - start_cyl;
            tries_q  <= '0;
        end else if (pulse_tick) begin
            if (recal_q) tries_q <= tries_q + 1'b1;
            else if (remain_q != '0) remain_q <= remain_q - 1'b1;
        end else if (gap_end) begin
            fail_q <= recal_q && !trk0[drv_q];
        end
    end

    // Outputs
    always_comb begin
        step_o      = (state_q == PH_PULSE);
        dir_o       = dir_q;
        sel_drive_o = drv_q;
        busy_o      = (state_q != PH_IDLE) ? (NUM_DRIVES'(1) << drv_q) : '0;
    end

    fstep_wait #(.CNT_W(RATE_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .load     (accept || pulse_tick),
        .load_val (wait_load_val),
        .expired  (wait_exp)
    );

    fstep_cyl_bank #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W), .DRV_W(DRV_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (pulse_tick),
        .step_up  (dir_q),
        .clear    ((state_q == PH_DONE) && recal_q && !fail_q),
        .wr_drv   (drv_q),
        .rd_a_drv (start_drive),
        .rd_b_drv (pend_drv),
        .rd_a     (cyl_start),
        .rd_b     (cyl_pend)
    );

    fstep_report #(.CYL_W(CYL_W), .DRV_W(DRV_W)) u_report (
        .clk           (clk),
        .rst_n         (rst_n),
        .done          (state_q == PH_DONE),
        .fail          (fail_q),
        .head          (head_q),
        .drv           (drv_q),
        .sense_req     (sense_req),
        .pend_cyl      (cyl_pend),
        .irq_o         (irq_o),
        .pend_drv      (pend_drv),
        .sense_valid_o (sense_valid_o),
        .sense_st0_o   (sense_st0_o),
        .sense_cyl_o   (sense_cyl_o)
    );

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> $stable(dir_o));

    // R6
    busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_o));

    // R7
    busy_drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o != '0) && $past(busy_o != '0) |-> $stable(busy_o));

    // R4
    step_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (busy_o != '0));
endmodule

// File: tb/tb_fdc_seek_stepper.sv
module tb_fdc_seek_stepper;
    localparam int CLK_PERIOD = 10;
    localparam int TICKDIV    = 4;
    localparam int WD_LIMIT   = 100000;

    logic       clk = 1'b0;
    logic       rst_n, tick_ms, start, start_recal, start_head, sense_req;
    logic [1:0] start_drive;
    logic [7:0] start_cyl;
    logic [3:0] step_rate, trk0;
    logic       step_o, dir_o, irq_o, sense_valid_o;
    logic [1:0] sel_drive_o;
    logic [3:0] busy_o;
    logic [7:0] sense_st0_o, sense_cyl_o;

    fdc_seek_stepper dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .start(start),
        .start_recal(start_recal), .start_drive(start_drive), .start_head(start_head),
        .start_cyl(start_cyl), .step_rate(step_rate), .trk0(trk0), .sense_req(sense_req),
        .step_o(step_o), .dir_o(dir_o), .sel_drive_o(sel_drive_o), .busy_o(busy_o),
        .irq_o(irq_o), .sense_valid_o(sense_valid_o), .sense_st0_o(sense_st0_o),
        .sense_cyl_o(sense_cyl_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  t_total = 0, t_bad = 0, c_total = 0, c_bad = 0, cyc = 0;
    bit  tests_done = 0;

    initial begin
        tick_ms = 1'b0;
        forever begin
            repeat (TICKDIV - 1) @(negedge clk);
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
        end
    end

    always @(posedge clk) cyc++;

    // Behavioural reference model
    int m_phase = 0, m_wait = 0, m_drv = 0, m_head = 0, m_recal = 0, m_dir = 0;
    int m_rate = 0, m_rem = 0, m_tries = 0, m_fail = 0, m_irq = 0, m_pst0 = 0, m_idrv = 0;
    int m_sv = 0, m_sst0 = 0, m_scyl = 0;
    int m_pcn [4] = '{0, 0, 0, 0};

    always @(posedge clk) begin
        int  d;
        bit  expd, fin;
        if (!rst_n) begin
            m_phase = 0; m_wait = 0; m_drv = 0; m_dir = 0; m_irq = 0; m_sv = 0;
            m_sst0 = 0; m_scyl = 0; m_pst0 = 0; m_idrv = 0;
            for (int i = 0; i < 4; i++) m_pcn[i] = 0;
        end else begin
            expd = tick_ms && (m_wait == 0);
            fin  = (m_phase == 4);
            m_sv = sense_req;
            if (sense_req) begin
                m_sst0 = m_irq ? m_pst0 : 'h80;
                m_scyl = m_irq ? m_pcn[m_idrv] : 0;
            end
            case (m_phase)
                0: if (start) begin
                    d = int'(start_drive);
                    m_drv = d; m_recal = start_recal; m_head = start_recal ? 0 : int'(start_head);
                    m_rate = int'(step_rate); m_tries = 0; m_fail = 0; m_wait = 1;
                    if (start_recal) begin
                        m_dir = 0;
                        m_phase = trk0[d] ? 4 : 1;
                    end else begin
                        m_dir = (int'(start_cyl) > m_pcn[d]) ? 1 : 0;
                        m_rem = m_dir ? int'(start_cyl) - m_pcn[d] : m_pcn[d] - int'(start_cyl);
                        m_phase = (m_rem == 0) ? 4 : 1;
                    end
                end
                1: if (expd) m_phase = 2; else if (tick_ms && m_wait > 0) m_wait--;
                2: if (tick_ms) begin
                    if (m_recal != 0) begin
                        m_tries++;
                        if (m_pcn[m_drv] > 0) m_pcn[m_drv]--;
                    end else begin
                        m_rem--;
                        if (m_dir != 0) m_pcn[m_drv]++; else m_pcn[m_drv]--;
                    end
                    m_wait = 15 - m_rate;
                    m_phase = 3;
                end
                3: if (expd) begin
                    if (m_recal == 0) m_phase = (m_rem == 0) ? 4 : 2;
                    else if (trk0[m_drv]) m_phase = 4;
                    else if (m_tries >= 77) begin m_fail = 1; m_phase = 4; end
                    else m_phase = 2;
                end else if (tick_ms && m_wait > 0) m_wait--;
                default: begin
                    m_phase = 0; m_irq = 1; m_idrv = m_drv;
                    m_pst0 = (m_fail ? 'h50 : 'h00) | 'h20 | (m_head << 2) | m_drv;
                    if (m_recal != 0 && m_fail == 0) m_pcn[m_drv] = 0;
                end
            endcase
            if (sense_req && !fin) m_irq = 0;
        end
    end

    task automatic cchk(input bit ok, input string tag, input int act, input int exp);
        c_total++;
        if (!ok) begin
            c_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int eb;
        if (rst_n) begin
            eb = (m_phase != 0) ? (1 << m_drv) : 0;
            cchk(int'(step_o) == int'(m_phase == 2), "R4 step level", int'(step_o), int'(m_phase == 2));
            cchk(int'(dir_o) == m_dir, "R2 direction level", int'(dir_o), m_dir);
            cchk(int'(busy_o) == eb, "R6 busy flags", int'(busy_o), eb);
            if (m_phase != 0)
                cchk(int'(sel_drive_o) == m_drv, "R6 selected drive", int'(sel_drive_o), m_drv);
            cchk(int'(irq_o) == m_irq, "R10 interrupt", int'(irq_o), m_irq);
            cchk(int'(sense_valid_o) == m_sv, "R11 sense valid", int'(sense_valid_o), m_sv);
            if (m_sv != 0) begin
                cchk(int'(sense_st0_o) == m_sst0, "R11 sense st0", int'(sense_st0_o), m_sst0);
                cchk(int'(sense_cyl_o) == m_scyl, "R11 sense cyl", int'(sense_cyl_o), m_scyl);
            end
        end
    end

    // Pulse monitor: rise count and run lengths in clocks
    int rises = 0, hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    bit step_prev = 0;
    always @(negedge clk) begin
        if (step_o && !step_prev) begin rises++; last_lo = lo_run; lo_run = 0; end
        if (!step_o && step_prev) begin last_hi = hi_run; hi_run = 0; end
        if (step_o) hi_run++; else lo_run++;
        step_prev = step_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        t_total++;
        if (!ok) begin
            t_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic issue(input bit rc, input int drv, input bit hd, input int cyl, input int rate);
        @(negedge clk);
        start = 1'b1; start_recal = rc; start_drive = 2'(drv); start_head = hd;
        start_cyl = 8'(cyl); step_rate = 4'(rate);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!(irq_o && busy_o == 0) && n < 3000) begin @(negedge clk); n++; end
        chk(irq_o && busy_o == 0, tag, int'(irq_o), 1);
    endtask

    task automatic sense(input int e_st0, input int e_cyl, input string tag);
        @(negedge clk);
        sense_req = 1'b1;
        @(negedge clk);
        sense_req = 1'b0;
        chk(sense_valid_o == 1'b1, tag, int'(sense_valid_o), 1);
        chk(int'(sense_st0_o) == e_st0, tag, int'(sense_st0_o), e_st0);
        chk(int'(sense_cyl_o) == e_cyl, tag, int'(sense_cyl_o), e_cyl);
        chk(irq_o == 1'b0, tag, int'(irq_o), 0);
    endtask

    initial begin
        int base;
        rst_n = 1'b0; start = 1'b0; start_recal = 1'b0; start_drive = '0; start_head = 1'b0;
        start_cyl = '0; step_rate = '0; trk0 = '0; sense_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!step_o && busy_o == 0 && !irq_o && !sense_valid_o, "R1 reset outputs",
            int'({step_o, busy_o, irq_o, sense_valid_o}), 0);
        // R12: nothing pending
        sense('h80, 0, "R12 empty sense");

        // R3: equal target, no pulse (also R1: cylinder starts at 0)
        base = rises;
        issue(0, 0, 0, 0, 15);
        wait_irq("R3 equal seek completes");
        chk(rises == base, "R3 equal seek pulses", rises - base, 0);
        sense('h20, 0, "R1 R10 equal seek st0");

        // R2/R3/R7: outward seek with an intruding start
        base = rises;
        issue(0, 1, 1, 5, 15);
        chk(dir_o == 1'b1, "R2 upward direction", int'(dir_o), 1);
        issue(0, 2, 0, 9, 15);
        chk(busy_o == 4'b0010, "R7 intruder ignored", int'(busy_o), 2);
        wait_irq("R3 seek completes");
        chk(rises - base == 5, "R3 pulse count up", rises - base, 5);
        chk(last_hi == TICKDIV, "R4 pulse width", last_hi, TICKDIV);
        chk(last_lo == TICKDIV, "R5 gap rate 15", last_lo, TICKDIV);
        sense('h25, 5, "R11 sense after seek");

        // R2/R5: inward seek, rate 14
        base = rises;
        issue(0, 1, 0, 2, 14);
        chk(dir_o == 1'b0, "R2 downward direction", int'(dir_o), 0);
        wait_irq("R3 inward completes");
        chk(rises - base == 3, "R3 pulse count down", rises - base, 3);
        chk(last_lo == 2 * TICKDIV, "R5 gap rate 14", last_lo, 2 * TICKDIV);
        sense('h21, 2, "R10 st0 inward");

        // R5: slowest rate
        base = rises;
        issue(0, 3, 0, 2, 0);
        wait_irq("R5 slow seek completes");
        chk(rises - base == 2, "R3 slow pulse count", rises - base, 2);
        chk(last_lo == 16 * TICKDIV, "R5 gap rate 0", last_lo, 16 * TICKDIV);
        sense('h23, 2, "R10 st0 drive 3");

        // R7: drive 2 still at 0 after ignored start
        base = rises;
        issue(0, 2, 1, 3, 15);
        wait_irq("R7 drive 2 seek completes");
        chk(rises - base == 3, "R7 drive 2 unchanged", rises - base, 3);
        sense('h26, 3, "R10 st0 head 1");

        // R8: recalibrate finds track zero after two pulses
        base = rises;
        issue(1, 1, 1, 0, 15);
        chk(dir_o == 1'b0, "R2 recal direction", int'(dir_o), 0);
        for (int i = 0; i < 3000 && !(irq_o && busy_o == 0); i++) begin
            @(negedge clk);
            if (rises - base >= 2 && !step_o) trk0[1] = 1'b1;
        end
        wait_irq("R8 recal completes");
        chk(rises - base == 2, "R8 recal pulse count", rises - base, 2);
        sense('h21, 0, "R8 recal st0");

        // R9: recalibrate never sees track zero
        base = rises;
        issue(1, 2, 0, 0, 15);
        wait_irq("R9 recal gives up");
        chk(rises - base == 77, "R9 step limit", rises - base, 77);
        sense('h72, 0, "R9 equipment check st0");

        // R8: already on track zero
        base = rises;
        issue(1, 1, 0, 0, 15);
        wait_irq("R8 immediate recal");
        chk(rises == base, "R8 no pulse at zero", rises - base, 0);
        sense('h21, 0, "R8 immediate st0");

        sense('h80, 0, "R12 sense after clear");
        repeat (4) @(negedge clk);
        tests_done = 1;
    end

    initial begin
        int wd;
        wd = 0;
        wait (tests_done || cyc >= WD_LIMIT);
        if (!tests_done) begin
            wd = 1;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
        end
        $display("test done: total=%0d bad=%0d", t_total + c_total + wd, t_bad + c_bad + wd);
        $finish;
    end
endmodule